// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a supervisory down-counter driven through a single 12-bit control word. Software picks a prescale ratio and one of four timeout intervals, enables the counter and must restart it before it expires. On the first expiry the block raises a warning flag and reloads a short, fixed grace period. An optional interrupt is driven from that flag. If the flag is still set when the grace period also runs out, the block latches a reset flag and emits a one-cycle system reset pulse. The reset flag survives a core-domain reset, so software can tell a watchdog reboot from a cold start. Only a power-on reset clears it.

The control word is written with `wr_en`/`wr_data` and is always visible on `rd_data`. The field layout is given in R1 to R12. Sequencing is held by a three-state machine:
- `ST_OFF`: counting paused, because the enable bit is clear.
- `ST_RUN`: counting prescaled ticks.
- `ST_HALT`: expired after the final stage; the counter is at zero.

The machine has these transitions:
- `restart`: any state goes to `ST_RUN` if the written enable is 1, otherwise to `ST_OFF`.
- `disable`: any state goes to `ST_OFF` when the enable bit is written 0.
- `resume`: `ST_OFF` goes to `ST_RUN` when enable is written 1 with a non-zero count. With a zero count it goes to `ST_HALT` instead.
- `final_expiry`: `ST_RUN` goes to `ST_HALT` when the count expires while the warning flag is set.
- `warn_expiry`: `ST_RUN` stays in `ST_RUN` with the grace period loaded.

Top module: `wdog_two_stage`

## Requirements
- R1: After power-on reset (`por_n` low), `rd_data` reads 0x400 and `irq` and `sys_rst_pulse` are low. This means clock select (bits 11:10) = 1 and every other bit is 0.
- R2: A core reset (`core_rst_n` low) returns the control word to 0x400 but leaves the reset flag (bit 2) at its previous value.
- R3: Writing 1 to bit 3 (warning flag) or bit 2 (reset flag) clears that flag. Writing 0 to either bit leaves it unchanged.
- R4: Writing bit 0 = 1 (restart) reloads the counter with 2^(BASE_SHIFT + IVL_STEP*k) ticks, where k is the interval field (bits 5:4) of the same write. It also clears the tick prescaler. Counting starts if that write also sets enable (bit 7). Bit 0 always reads 0.
- R5: Clock select (bits 11:10) code c makes one counter tick every 2^PSc clock cycles. An enabled restart with interval N ticks sets the warning flag on the N*2^PSc-th clock edge after the restart write.
- R6: The first expiry, with the warning flag clear, sets the warning flag and reloads GRACE_CYCLES ticks, and counting continues. `irq` is high while the warning flag, interrupt enable (bit 6) and enable (bit 7) are all set.
- R7: An expiry with the warning flag already set and reset enable (bit 1) set sets the reset flag. It also drives `sys_rst_pulse` high for exactly one cycle and halts the counter.
- R8: An expiry with the warning flag set and reset enable clear produces no reset pulse and no reset flag, and halts the counter.
- R9: If software clears the warning flag during the grace period, the grace expiry is treated as a first expiry again. The flag is set, the grace period is reloaded, and no reset pulse occurs.
- R10: Clearing enable without restart pauses counting and the prescaler and forces `irq` low. Setting enable again resumes from the remaining count without a reload.
- R11: A clock cycle in which a register write occurs does not advance the prescaler or the counter.
- R12: The freeze-enable bit (bit 9) and all other writable fields read back as written, and bit 8 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous power-on reset, active low; clears everything |
| core_rst_n | input | 1 | Synchronous core reset, active low; keeps the reset flag |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 12 | Control word write value |
| rd_data | output | 12 | Current control word |
| irq | output | 1 | Warning interrupt level |
| sys_rst_pulse | output | 1 | One-cycle system reset request |

## Verification
The assertions assume three things about the inputs. First, writes are never issued while either reset is low. Second, a restart always uses an interval of at least two ticks, so a freshly loaded count is never already at its last tick. Third, both reset inputs are synchronous to `clk`. The stimulus holds to these assumptions as follows:
- It drives every write on the falling edge and only after both resets have been released.
- It uses only the defined interval codes.
- It applies resets for whole cycles.

This keeps every expiry in a cycle with no concurrent write, which is the condition under which the flag and pulse properties are stated.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } wdog_state_e;

    localparam int unsigned CTRL_W     = 12;
    localparam int unsigned B_RESTART  = 0;
    localparam int unsigned B_RST_EN   = 1;
    localparam int unsigned B_RST_FLAG = 2;
    localparam int unsigned B_WARN     = 3;
    localparam int unsigned B_IVL_LO   = 4;
    localparam int unsigned B_IE       = 6;
    localparam int unsigned B_EN       = 7;
    localparam int unsigned B_FRZ      = 9;
    localparam int unsigned B_CSEL_LO  = 10;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int PS0   = 0,
    parameter int PS1   = 8,
    parameter int PS2   = 11,
    parameter int PS3   = 16,
    parameter int PRE_W = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] limit;

    always_comb begin
        unique case (sel)
            2'd0:    limit = PRE_W'((1 << PS0) - 1);
            2'd1:    limit = PRE_W'((1 << PS1) - 1);
            2'd2:    limit = PRE_W'((1 << PS2) - 1);
            default: limit = PRE_W'((1 << PS3) - 1);
        endcase
    end

    assign tick = run && (pre_cnt >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pre_cnt <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
        end else if (run) begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt #(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart_wr,
    input  logic        en_next,
    input  logic        cnt_zero,
    input  logic        timeout,
    input  logic        warn_flag,
    input  logic        rst_en,
    output wdog_state_e state,
    output logic        rst_pulse
);
    wdog_state_e nxt;

    always_comb begin
        nxt = state;
        if (restart_wr) begin
            nxt = en_next ? ST_RUN : ST_OFF;
        end else if (!en_next) begin
            nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:  nxt = cnt_zero ? ST_HALT : ST_RUN;
                ST_RUN:  nxt = (timeout && warn_flag) ? ST_HALT : ST_RUN;
                ST_HALT: nxt = ST_HALT;
                default: nxt = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rst_pulse <= 1'b0;
        else        rst_pulse <= (state == ST_RUN) && timeout && warn_flag && rst_en;
    end
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int PS0          = 0,
    parameter int PS1          = 8,
    parameter int PS2          = 11,
    parameter int PS3          = 16,
    parameter int BASE_SHIFT   = 14,
    parameter int IVL_STEP     = 2,
    parameter int GRACE_CYCLES = 1024
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              core_rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    output logic              irq,
    output logic              sys_rst_pulse
);
    localparam int PRE_W = max2(max2(PS0, PS1), max2(PS2, PS3)) + 1;
    localparam int CNT_W = max2(BASE_SHIFT + 3 * IVL_STEP + 1, $clog2(GRACE_CYCLES + 1) + 1);

    logic        rst_all_n;
    logic [1:0]  csel;
    logic        frz, en, ie, warn, rflag, rst_en;
    logic [1:0]  ivl;
    logic        restart_wr, en_next, run, tick, timeout;
    logic        cnt_load;
    logic [CNT_W-1:0] cnt, load_val, ivl_load;
    wdog_state_e state;
    logic        unused_bit8;

    assign rst_all_n   = por_n && core_rst_n;
    assign restart_wr  = wr_en && wr_data[B_RESTART];
    assign en_next     = wr_en ? wr_data[B_EN] : en;
    assign run         = (state == ST_RUN) && !wr_en;
    assign timeout     = tick && (cnt == CNT_W'(1));
    assign ivl_load    = CNT_W'(1) << (BASE_SHIFT + IVL_STEP * int'(wr_data[B_IVL_LO +: 2]));
    assign cnt_load    = restart_wr || timeout;
    assign load_val    = restart_wr ? ivl_load : (warn ? '0 : CNT_W'(GRACE_CYCLES));
    assign unused_bit8 = wr_data[8];

    wdog_prescale #(.PS0(PS0), .PS1(PS1), .PS2(PS2), .PS3(PS3), .PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_all_n), .clear(restart_wr), .run(run), .sel(csel), .tick(tick)
    );

    wdog_downcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_all_n), .load(cnt_load), .load_val(load_val),
        .dec(tick && !timeout), .cnt(cnt)
    );

    wdog_fsm u_fsm (
        .clk(clk), .rst_n(rst_all_n), .restart_wr(restart_wr), .en_next(en_next),
        .cnt_zero(cnt == '0), .timeout(timeout), .warn_flag(warn), .rst_en(rst_en),
        .state(state), .rst_pulse(sys_rst_pulse)
    );

    // Control fields cleared by either reset
    always_ff @(posedge clk) begin
        if (!rst_all_n) begin
            csel   <= 2'd1;
            frz    <= 1'b0;
            en     <= 1'b0;
            ie     <= 1'b0;
            ivl    <= 2'd0;
            warn   <= 1'b0;
            rst_en <= 1'b0;
        end else if (wr_en) begin
            csel   <= wr_data[B_CSEL_LO +: 2];
            frz    <= wr_data[B_FRZ];
            en     <= wr_data[B_EN];
            ie     <= wr_data[B_IE];
            ivl    <= wr_data[B_IVL_LO +: 2];
            rst_en <= wr_data[B_RST_EN];
            if (wr_data[B_WARN]) warn <= 1'b0;
        end else if (timeout) begin
            warn <= 1'b1;
        end
    end

    // Reset flag: only power-on reset clears it
    always_ff @(posedge clk) begin
        if (!por_n) begin
            rflag <= 1'b0;
        end else if (core_rst_n) begin
            if (wr_en && wr_data[B_RST_FLAG]) rflag <= 1'b0;
            else if (timeout && warn && rst_en) rflag <= 1'b1;
        end
    end

    assign rd_data = {csel, frz, 1'b0, en, ie, ivl, warn, rflag, rst_en, 1'b0};
    assign irq     = warn && ie && en;

    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_all_n)
        sys_rst_pulse |=> !sys_rst_pulse);
    assert_pulse_flag_R7: assert property (@(posedge clk) disable iff (!rst_all_n)
        sys_rst_pulse |-> rd_data[B_RST_FLAG]);
    assert_halt_zero_R7: assert property (@(posedge clk) disable iff (!rst_all_n)
        (state == ST_HALT) |-> (cnt == '0));
    assert_grace_load_R6: assert property (@(posedge clk) disable iff (!rst_all_n)
        (timeout && !warn) |=> (cnt == CNT_W'(GRACE_CYCLES)));
    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_all_n)
        (wr_en && wr_data[B_WARN]) |=> !rd_data[B_WARN]);
    assert_off_hold_R10: assert property (@(posedge clk) disable iff (!rst_all_n)
        ((state == ST_OFF) && !restart_wr) |=> $stable(cnt));
    assert_write_nocount_R11: assert property (@(posedge clk) disable iff (!rst_all_n)
        (wr_en && !wr_data[B_RESTART]) |=> $stable(cnt));
endmodule

// File: tb/wdog_two_stage_tb.sv
module wdog_two_stage_tb;
    localparam int PS[4] = '{0, 1, 2, 3};
    localparam int BS = 3, STEP = 2, GR = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic por_n = 1'b0, core_n = 1'b0, wr_en = 1'b0;
    logic [11:0] wr_data = '0;
    logic [11:0] rd_data;
    logic irq, sys_rst_pulse;

    wdog_two_stage #(.PS0(PS[0]), .PS1(PS[1]), .PS2(PS[2]), .PS3(PS[3]),
        .BASE_SHIFT(BS), .IVL_STEP(STEP), .GRACE_CYCLES(GR)) u_dut (
        .clk(clk), .por_n(por_n), .core_rst_n(core_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq), .sys_rst_pulse(sys_rst_pulse));

    int n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    bit saw_pulse = 0;

    // behavioural reference model
    int m_csel = 1, m_frz = 0, m_en = 0, m_ie = 0, m_ivl = 0, m_warn = 0, m_rflag = 0, m_rsten = 0;
    int m_cnt = 0, m_pre = 0, m_state = 0;
    bit m_pulse = 0;

    function automatic int m_rd();
        return (m_csel << 10) | (m_frz << 9) | (m_en << 7) | (m_ie << 6) | (m_ivl << 4) |
               (m_warn << 3) | (m_rflag << 2) | (m_rsten << 1);
    endfunction

    always @(posedge clk) begin
        bit tick;
        if (!por_n || !core_n) begin
            m_csel = 1; m_frz = 0; m_en = 0; m_ie = 0; m_ivl = 0; m_warn = 0; m_rsten = 0;
            m_cnt = 0; m_pre = 0; m_state = 0; m_pulse = 0;
            if (!por_n) m_rflag = 0;
        end else begin
            tick = 0; m_pulse = 0;
            if (m_state == 1 && !wr_en) begin
                if (m_pre >= (1 << PS[m_csel]) - 1) begin tick = 1; m_pre = 0; end
                else m_pre++;
            end
            if (tick) begin
                if (m_cnt == 1) begin
                    if (m_warn == 0) begin m_warn = 1; m_cnt = GR; end
                    else begin
                        m_cnt = 0; m_state = 2;
                        if (m_rsten != 0) begin m_rflag = 1; m_pulse = 1; end
                    end
                end else m_cnt--;
            end
            if (wr_en) begin
                m_csel = int'(wr_data[11:10]); m_frz = int'(wr_data[9]); m_en = int'(wr_data[7]);
                m_ie = int'(wr_data[6]); m_ivl = int'(wr_data[5:4]); m_rsten = int'(wr_data[1]);
                if (wr_data[3]) m_warn = 0;
                if (wr_data[2]) m_rflag = 0;
                if (wr_data[0]) begin
                    m_cnt = 1 << (BS + STEP * m_ivl); m_pre = 0; m_state = m_en;
                end else if (m_en == 0) m_state = 0;
                else if (m_state == 0) m_state = (m_cnt == 0) ? 2 : 1;
            end
        end
    end

    always @(posedge clk) begin
        int exp_irq;
        #5;
        exp_irq = (m_warn != 0 && m_ie != 0 && m_en != 0) ? 1 : 0;
        n_cmp++;
        if (rd_data !== 12'(m_rd()) || irq !== exp_irq[0] || sys_rst_pulse !== m_pulse) begin
            n_bad++;
            $display("FAIL %s: actual rd=%h irq=%b pulse=%b expected rd=%h irq=%0d pulse=%b",
                     cur_req, rd_data, irq, sys_rst_pulse, 12'(m_rd()), exp_irq, m_pulse);
        end
        if (sys_rst_pulse === 1'b1) saw_pulse = 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [11:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // count rising edges until the chosen output is high; returns at a falling edge
    task automatic edges_until(input bit want_pulse, input int lim, output int k);
        k = 0;
        while (k < lim) begin
            @(posedge clk); #5; k++;
            if ((want_pulse ? sys_rst_pulse : irq) === 1'b1) break;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired (all requirements)");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        por_n = 1'b1; core_n = 1'b1;
        @(negedge clk);
        chk(rd_data == 12'h400 && !irq && !sys_rst_pulse, "R1", int'(rd_data), 'h400);

        cur_req = "R12";
        wr(12'hF62);
        chk(rd_data == 12'hE62, "R12", int'(rd_data), 'hE62);

        cur_req = "R5";
        wr(12'h4C3);
        chk(rd_data[0] == 1'b0, "R4", int'(rd_data[0]), 0);
        edges_until(1'b0, 100, k);
        chk(k == 16, "R5", k, 16);
        chk(rd_data[3] == 1'b1 && irq, "R6", int'(rd_data[3]), 1);

        cur_req = "R7";
        edges_until(1'b1, 100, k);
        chk(k == 12, "R7", k, 12);
        @(posedge clk); #5;
        chk(sys_rst_pulse == 1'b0 && rd_data[2], "R7", int'(sys_rst_pulse), 0);
        @(negedge clk);

        cur_req = "R2";
        core_n = 1'b0; @(negedge clk); core_n = 1'b1; @(negedge clk);
        chk(rd_data == 12'h404, "R2", int'(rd_data), 'h404);
        por_n = 1'b0; @(negedge clk); por_n = 1'b1; @(negedge clk);
        chk(rd_data == 12'h400, "R1", int'(rd_data), 'h400);

        cur_req = "R3";
        wr(12'h0C3);
        edges_until(1'b0, 100, k);
        chk(k == 8, "R6", k, 8);
        wr(12'h0C2);
        chk(rd_data[3] == 1'b1, "R3", int'(rd_data[3]), 1);
        wr(12'h0CA);
        chk(rd_data[3] == 1'b0 && !irq, "R3", int'(rd_data[3]), 0);

        cur_req = "R9";
        saw_pulse = 0;
        edges_until(1'b0, 100, k);
        chk(irq && !saw_pulse, "R9", int'(saw_pulse), 0);
        edges_until(1'b1, 100, k);
        chk(k == 6, "R9", k, 6);

        cur_req = "R8";
        wr(12'h0CC);
        chk(rd_data[3:2] == 2'b00, "R3", int'(rd_data[3:2]), 0);
        wr(12'h0C1);
        edges_until(1'b0, 100, k);
        saw_pulse = 0;
        repeat (12) @(negedge clk);
        chk(!saw_pulse && rd_data[2] == 1'b0, "R8", int'(saw_pulse), 0);

        cur_req = "R10";
        wr(12'h4C9);
        repeat (5) @(negedge clk);
        wr(12'h440);
        repeat (30) @(negedge clk);
        chk(!irq, "R10", int'(irq), 0);
        wr(12'h4C0);
        edges_until(1'b0, 100, k);
        chk(k == 11, "R10", k, 11);
        wr(12'h440);
        chk(!irq && rd_data[3], "R10", int'(irq), 0);

        cur_req = "R11";
        wr(12'h0C9);
        wr(12'h0C0); wr(12'h0C0); wr(12'h0C0);
        edges_until(1'b0, 100, k);
        chk(k == 8, "R11", k, 8);

        repeat (4) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule